// File: doc/BRIEF.md
# Start-Bit Configuration Transaction Engine

This block sits behind three software-visible words: a command word, an operand/result word and a completion word. Software loads an operand (for writes), then writes a command word whose top bit launches a transaction. The command word names a controller, a function, a board site, a stack position and a device index. The engine checks these fields against its accept rules. An accepted transaction reads or updates one entry of an internal table, or raises a one-cycle action pulse. The engine always reports completion, and reports an error when it rejects the transaction.

The tables are a six-entry main-board oscillator table with fixed reset frequencies, a parameter-sized add-on-board oscillator table whose reset contents come from a parameter, and a parameter-sized, read-only add-on-board voltage table. The whole transaction takes effect on the clock edge that accepts the command write. The next cycle shows the result in the registers and any action pulse on the outputs. The register select encoding is 0 = command, 1 = operand, 2 = completion. Select 3 reads as zero and ignores writes.

Top module: `cfgx_engine`

## Requirements
- R1: The command word keeps every bit written to it except bit 31 (launch) and bits 19:18, which always read 0. Its fields are: bit 30 direction (1 = write), bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device. Select 3 reads as zero.
- R2: A command write with bit 31 clear only stores the word. No transaction runs and the completion word is unchanged.
- R3: A command write with bit 31 set runs a transaction. The completion word then reads 1 if the transaction was accepted.
- R4: A transaction is rejected, and the completion word reads 3, if the controller is nonzero, the position is nonzero or the site is above 1.
- R5: Function 1 reads or writes oscillator entry `device`: site 0 uses the six-entry main-board table, site 1 uses the add-on table. An index outside the table is rejected. After reset the main-board entries are 50000000, 23750000, then 24000000 for the remaining four, and the add-on entries equal their parameter values.
- R6: Function 2 is read only. At site 0 device 0 it returns 3300000; at site 1 it returns add-on voltage entry `device` if that index is in range. Any write, or any other index, is rejected.
- R7: Writes with function 7 or 11 at site 0 device 0 are accepted and change nothing else. The same functions used as reads, or aimed at another device, are rejected.
- R8: An accepted write with function 8 or 9 at site 0 device 0 raises `shutdown_req` or `reboot_req` for exactly the one cycle after the command write. Rejected transactions raise neither.
- R9: A write transaction takes its operand from the operand word. An accepted read replaces the operand word with the result; a rejected read leaves it unchanged.
- R10: A write to the completion word keeps only bits 1:0 of the written data.
- R11: After reset, the command, operand and completion words read 0 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 2 | Word select: 0 command, 1 operand, 2 completion, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The hardest case to reach is the boundary between an accepted and a rejected index. The index has to land exactly one past the end of each table, and a rejected read must still leave the operand word untouched. The stimulus first loads the operand word with a known value through an accepted read. It then issues the out-of-range read and reads the operand back. Action pulses are observed in the single cycle after the launching write and confirmed low in the cycle after that.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int WORD_W   = 32;
    localparam int DEV_W    = 12;
    localparam int MB_OSC_N = 6;

    localparam logic [WORD_W-1:0] MB_VOLT_MV = 32'd3_300_000;

    // bits that survive into the stored command word
    localparam logic [WORD_W-1:0] CMD_KEEP_MASK = 32'h7FF3_FFFF;

    typedef enum logic [1:0] {
        RS_CMD  = 2'd0,
        RS_OPND = 2'd1,
        RS_DONE = 2'd2,
        RS_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [5:0] {
        FN_OSC      = 6'd1,
        FN_VOLT     = 6'd2,
        FN_VIDMUX   = 6'd7,
        FN_HALT     = 6'd8,
        FN_RESTART  = 6'd9,
        FN_DISPMODE = 6'd11
    } fn_code_e;

    typedef struct packed {
        logic             launch;
        logic             is_wr;
        logic [3:0]       ctl;
        logic [5:0]       func;
        logic [1:0]       rsvd;
        logic [1:0]       site;
        logic [3:0]       pos;
        logic [DEV_W-1:0] dev;
    } cmd_word_t;

    typedef struct packed {
        logic              ok;
        logic [WORD_W-1:0] rd_val;
        logic              wr_mb;
        logic              wr_db;
        logic              halt;
        logic              restart;
    } txn_res_t;

    function automatic logic [WORD_W-1:0] mb_osc_init(input int idx);
        case (idx)
            0:       return 32'd50_000_000;
            1:       return 32'd23_750_000;
            default: return 32'd24_000_000;
        endcase
    endfunction

    function automatic logic in_range(input logic [DEV_W-1:0] dev, input int n);
        return {20'd0, dev} < n;
    endfunction

endpackage

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank
    import cfgx_pkg::*;
#(
    parameter int N = 2,
    parameter logic [N-1:0][WORD_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DEV_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= INIT[g];
            else if (we && idx == DEV_W'(g))
                ent[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (idx == DEV_W'(i)) rdata = ent[i];
    end

    p_bank_index_r5: assert property (@(posedge clk) disable iff (rst)
        we |-> in_range(idx, N));

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N  = 2,
    parameter int DB_VOLT_N = 2,
    parameter logic [DB_VOLT_N-1:0][WORD_W-1:0] DB_VOLT = '0
) (
    input  logic              is_wr,
    input  logic [3:0]        ctl,
    input  logic [5:0]        func,
    input  logic [1:0]        site,
    input  logic [3:0]        pos,
    input  logic [DEV_W-1:0]  dev,
    input  logic [WORD_W-1:0] mb_rd,
    input  logic [WORD_W-1:0] db_rd,
    output txn_res_t          res
);
    logic              base_ok;
    logic              at_mb;
    logic              at_db;
    logic              mb_dev0;
    logic [WORD_W-1:0] volt_val;

    assign at_mb   = site == 2'd0;
    assign at_db   = site == 2'd1;
    assign base_ok = (ctl == 4'd0) && (pos == 4'd0) && (at_mb || at_db);
    assign mb_dev0 = at_mb && (dev == '0);

    always_comb begin
        volt_val = '0;
        for (int i = 0; i < DB_VOLT_N; i++)
            if (dev == DEV_W'(i)) volt_val = DB_VOLT[i];
    end

    always_comb begin
        res = '0;
        if (base_ok) begin
            case (func)
                FN_OSC: begin
                    if (at_mb && in_range(dev, MB_OSC_N)) begin
                        res.ok     = 1'b1;
                        res.rd_val = mb_rd;
                        res.wr_mb  = is_wr;
                    end else if (at_db && in_range(dev, DB_OSC_N)) begin
                        res.ok     = 1'b1;
                        res.rd_val = db_rd;
                        res.wr_db  = is_wr;
                    end
                end
                FN_VOLT: begin
                    if (!is_wr && mb_dev0) begin
                        res.ok     = 1'b1;
                        res.rd_val = MB_VOLT_MV;
                    end else if (!is_wr && at_db && in_range(dev, DB_VOLT_N)) begin
                        res.ok     = 1'b1;
                        res.rd_val = volt_val;
                    end
                end
                FN_VIDMUX, FN_DISPMODE: res.ok = is_wr && mb_dev0;
                FN_HALT: begin
                    res.ok   = is_wr && mb_dev0;
                    res.halt = is_wr && mb_dev0;
                end
                FN_RESTART: begin
                    res.ok      = is_wr && mb_dev0;
                    res.restart = is_wr && mb_dev0;
                end
                default: res = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N  = 2,
    parameter int DB_VOLT_N = 2,
    parameter logic [DB_OSC_N-1:0][WORD_W-1:0]  DB_OSC_INIT = {32'd45_000_000, 32'd60_000_000},
    parameter logic [DB_VOLT_N-1:0][WORD_W-1:0] DB_VOLT     = {32'd1_000_000, 32'd900_000}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        shutdown_req,
    output logic        reboot_req
);
    function automatic logic [MB_OSC_N-1:0][WORD_W-1:0] mb_init_vec();
        logic [MB_OSC_N-1:0][WORD_W-1:0] v;
        for (int i = 0; i < MB_OSC_N; i++) v[i] = mb_osc_init(i);
        return v;
    endfunction

    localparam logic [MB_OSC_N-1:0][WORD_W-1:0] MB_INIT = mb_init_vec();

    cmd_word_t         wcmd;
    logic              launch;
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] opnd_q;
    logic [1:0]        done_q;
    logic [WORD_W-1:0] mb_rd;
    logic [WORD_W-1:0] db_rd;
    txn_res_t          res;
    logic              halt_q;
    logic              restart_q;

    assign wcmd   = cmd_word_t'(reg_wdata);
    assign launch = reg_wr && (reg_sel == RS_CMD) && wcmd.launch;

    cfgx_osc_bank #(.N(MB_OSC_N), .INIT(MB_INIT)) u_mb_osc (
        .clk   (clk),
        .rst   (rst),
        .we    (launch && res.wr_mb),
        .idx   (wcmd.dev),
        .wdata (opnd_q),
        .rdata (mb_rd)
    );

    cfgx_osc_bank #(.N(DB_OSC_N), .INIT(DB_OSC_INIT)) u_db_osc (
        .clk   (clk),
        .rst   (rst),
        .we    (launch && res.wr_db),
        .idx   (wcmd.dev),
        .wdata (opnd_q),
        .rdata (db_rd)
    );

    cfgx_decode #(.DB_OSC_N(DB_OSC_N), .DB_VOLT_N(DB_VOLT_N), .DB_VOLT(DB_VOLT)) u_dec (
        .is_wr (wcmd.is_wr),
        .ctl   (wcmd.ctl),
        .func  (wcmd.func),
        .site  (wcmd.site),
        .pos   (wcmd.pos),
        .dev   (wcmd.dev),
        .mb_rd (mb_rd),
        .db_rd (db_rd),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            opnd_q    <= '0;
            done_q    <= '0;
            halt_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            halt_q    <= launch && res.halt;
            restart_q <= launch && res.restart;
            if (reg_wr) begin
                case (reg_sel)
                    RS_CMD: begin
                        cmd_q <= reg_wdata & CMD_KEEP_MASK;
                        if (wcmd.launch) begin
                            done_q <= {~res.ok, 1'b1};
                            if (res.ok && !wcmd.is_wr) opnd_q <= res.rd_val;
                        end
                    end
                    RS_OPND: opnd_q <= reg_wdata;
                    RS_DONE: done_q <= reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_sel)
            RS_CMD:  reg_rdata = cmd_q;
            RS_OPND: reg_rdata = opnd_q;
            RS_DONE: reg_rdata = {30'd0, done_q};
            default: reg_rdata = '0;
        endcase
    end

    assign shutdown_req = halt_q;
    assign reboot_req   = restart_q;

    p_launch_done_r3: assert property (@(posedge clk) disable iff (rst)
        launch |=> done_q[0]);

    p_reject_ctl_r4: assert property (@(posedge clk) disable iff (rst)
        (launch && wcmd.ctl != 4'd0) |=> done_q == 2'b11);

    p_bad_read_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (launch && !wcmd.is_wr && !res.ok) |=> opnd_q == $past(opnd_q));

    p_halt_origin_r8: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(launch && wcmd.is_wr && wcmd.func == FN_HALT));

    p_restart_origin_r8: assert property (@(posedge clk) disable iff (rst)
        reboot_req |-> $past(launch && wcmd.is_wr && wcmd.func == FN_RESTART));

    p_done_write_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == RS_DONE) |=> done_q == $past(reg_wdata[1:0]));

endmodule

// File: tb/cfgx_engine_test.sv
module cfgx_engine_test;

    typedef struct {
        logic [31:0] rdata;
        logic        sh;
        logic        rb;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        shutdown_req;
    logic        reboot_req;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    cfgx_engine uut (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .shutdown_req (shutdown_req),
        .reboot_req   (reboot_req)
    );

    localparam logic [1:0] S_CMD = 2'd0, S_OP = 2'd1, S_DN = 2'd2, S_NO = 2'd3;

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_sel   = s;
        reg_wdata = d;
    endtask

    task automatic chk(input logic [1:0] s, input logic [31:0] e,
                       input logic sh, input logic rb, input string tag);
        exp_t it;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_sel   = s;
        reg_wdata = '0;
        it.rdata = e; it.sh = sh; it.rb = rb; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: pops one expected item per cycle, after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                n_cmp++;
                if (reg_rdata !== it.rdata || shutdown_req !== it.sh || reboot_req !== it.rb) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h sh=%b rb=%b expected rdata=%h sh=%b rb=%b",
                             it.tag, reg_rdata, shutdown_req, reboot_req, it.rdata, it.sh, it.rb);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk(S_CMD, 32'h0, 0, 0, "R11 cmd");
        chk(S_OP,  32'h0, 0, 0, "R11 opnd");
        chk(S_DN,  32'h0, 0, 0, "R11 done");

        // R1 / R2: store without launch
        wr(S_CMD, 32'h7FFF_FFFF);
        chk(S_CMD, 32'h7FF3_FFFF, 0, 0, "R1 masked store");
        chk(S_DN,  32'h0, 0, 0, "R2 no launch");
        wr(S_NO, 32'hDEAD_BEEF);
        chk(S_NO, 32'h0, 0, 0, "R1 sel3 zero");

        // R10 completion write
        wr(S_DN, 32'hFFFF_FFFE);
        chk(S_DN, 32'h2, 0, 0, "R10 low bits");
        wr(S_DN, 32'h0);

        // R5 / R3 main-board oscillator reads
        wr(S_CMD, 32'h8010_0001);
        chk(S_DN,  32'h1, 0, 0, "R3 done");
        chk(S_OP,  32'd23_750_000, 0, 0, "R5 mb1 reset");
        chk(S_CMD, 32'h0010_0001, 0, 0, "R1 launch reads 0");
        wr(S_CMD, 32'h8010_0000);
        chk(S_OP,  32'd50_000_000, 0, 0, "R5 mb0 reset");
        wr(S_CMD, 32'h8010_0005);
        chk(S_OP,  32'd24_000_000, 0, 0, "R5 mb5 reset");
        // out of range, operand kept
        wr(S_CMD, 32'h8010_0006);
        chk(S_DN,  32'h3, 0, 0, "R5 mb6 reject");
        chk(S_OP,  32'd24_000_000, 0, 0, "R9 failed read keeps");

        // R9 write uses operand
        wr(S_OP,  32'd12_345_678);
        wr(S_CMD, 32'hC010_0002);
        chk(S_DN,  32'h1, 0, 0, "R5 mb write ok");
        wr(S_OP,  32'h0);
        wr(S_CMD, 32'h8010_0002);
        chk(S_OP,  32'd12_345_678, 0, 0, "R9 mb write readback");

        // add-on oscillators
        wr(S_CMD, 32'h8011_0000);
        chk(S_OP,  32'd60_000_000, 0, 0, "R5 db0 reset");
        wr(S_CMD, 32'h8011_0001);
        chk(S_OP,  32'd45_000_000, 0, 0, "R5 db1 reset");
        wr(S_CMD, 32'h8011_0002);
        chk(S_DN,  32'h3, 0, 0, "R5 db2 reject");
        wr(S_OP,  32'd7_777);
        wr(S_CMD, 32'hC011_0001);
        chk(S_DN,  32'h1, 0, 0, "R5 db write ok");
        wr(S_CMD, 32'h8011_0001);
        chk(S_OP,  32'd7_777, 0, 0, "R5 db write readback");

        // R6 voltage
        wr(S_CMD, 32'h8020_0000);
        chk(S_OP,  32'd3_300_000, 0, 0, "R6 mb volt");
        wr(S_CMD, 32'h8021_0000);
        chk(S_OP,  32'd900_000, 0, 0, "R6 db volt0");
        wr(S_CMD, 32'h8021_0001);
        chk(S_OP,  32'd1_000_000, 0, 0, "R6 db volt1");
        wr(S_CMD, 32'h8021_0002);
        chk(S_DN,  32'h3, 0, 0, "R6 db volt2 reject");
        chk(S_OP,  32'd1_000_000, 0, 0, "R9 volt reject keeps");
        wr(S_CMD, 32'hC020_0000);
        chk(S_DN,  32'h3, 0, 0, "R6 volt write reject");
        wr(S_CMD, 32'h8020_0001);
        chk(S_DN,  32'h3, 0, 0, "R6 mb volt dev1 reject");

        // R4 reject rules
        wr(S_CMD, 32'h8410_0000);
        chk(S_DN,  32'h3, 0, 0, "R4 ctl nonzero");
        wr(S_CMD, 32'h8010_1000);
        chk(S_DN,  32'h3, 0, 0, "R4 pos nonzero");
        wr(S_CMD, 32'h8012_0000);
        chk(S_DN,  32'h3, 0, 0, "R4 site2");
        wr(S_CMD, 32'hFFFF_FFFF);
        chk(S_DN,  32'h3, 0, 0, "R4 all ones");
        chk(S_CMD, 32'h7FF3_FFFF, 0, 0, "R1 all ones stored");

        // R7 accept-only functions
        wr(S_CMD, 32'hC070_0000);
        chk(S_DN,  32'h1, 0, 0, "R7 fn7 write");
        wr(S_CMD, 32'hC0B0_0000);
        chk(S_DN,  32'h1, 0, 0, "R7 fn11 write");
        wr(S_CMD, 32'h8070_0000);
        chk(S_DN,  32'h3, 0, 0, "R7 fn7 read reject");
        wr(S_CMD, 32'hC0B0_0001);
        chk(S_DN,  32'h3, 0, 0, "R7 fn11 dev1 reject");
        wr(S_CMD, 32'h8010_0002);
        chk(S_OP,  32'd12_345_678, 0, 0, "R7 no side effect");

        // R8 action pulses
        wr(S_CMD, 32'hC080_0000);
        chk(S_DN,  32'h1, 1, 0, "R8 halt pulse");
        chk(S_DN,  32'h1, 0, 0, "R8 halt one cycle");
        wr(S_CMD, 32'hC090_0000);
        chk(S_DN,  32'h1, 0, 1, "R8 restart pulse");
        chk(S_DN,  32'h1, 0, 0, "R8 restart one cycle");
        wr(S_CMD, 32'hC080_0001);
        chk(S_DN,  32'h3, 0, 0, "R8 halt dev1 reject");
        wr(S_CMD, 32'h8090_0000);
        chk(S_DN,  32'h3, 0, 0, "R8 restart read reject");

        // R2 store after launch keeps completion
        wr(S_CMD, 32'h0010_0003);
        chk(S_DN,  32'h3, 0, 0, "R2 store keeps done");

        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule